// File: doc/BRIEF.md
# Serial Transmitter Sharing a Port Pin, with Break Support

The block drives one output pin that is shared between a serial transmitter and a general-purpose port bit. When the enable input is low, the transmitter is held in its initial state and the pin simply follows the port value and direction bits. This means software can hold the line at mark before enabling by setting both port bits to 1. It can also produce a break in the middle of a frame: it sets the port value to 0 and then drops the enable. The frame in flight is abandoned at once, and the line sits at 0 for as long as software likes.

When enabled, the pin is always driven. It idles at 1 and carries frames that start whenever the holding register reports new data. Two framings are selectable. The asynchronous framing has a start bit, eight data bits, an optional parity bit and a stop bit. The clocked synchronous framing has eight bare data bits and a serial clock output. In synchronous mode a pending receive error of any kind holds back the start of the next frame until software clears it. The block raises a one-cycle acknowledge when it takes a byte from the holding register, and reports with a transmit-end flag when the line has gone idle.

Top module: `sertx_pin`

## Requirements
- R1: While `tx_en` is 0, `pin_out` equals `port_dr`, `pin_oe` equals `port_ddr`, and `sck_out` is 1, all in the same cycle.
- R2: While `tx_en` is 1, `pin_oe` is 1 whatever `port_ddr` holds, and with no frame in progress `pin_out` is 1.
- R3: An asynchronous frame without parity is a 0 start bit, the eight bits of `tx_data` LSB first, and a 1 stop bit. Each bit lasts OVS (16) clock cycles, and the first bit appears in the cycle after `load_ack`.
- R4: With `par_en` = 1 in asynchronous mode, a parity bit follows the data and comes before the stop bit. It makes the count of ones even when `par_odd` = 0 and odd when `par_odd` = 1.
- R5: Dropping `tx_en` abandons any frame at the next clock edge. After `tx_en` returns to 1 with no data pending, the pin idles at 1 and `tx_end` is 1.
- R6: A break is made by setting `port_dr` to 0 mid-frame and then clearing `tx_en`. The pin then shows 0 at once and keeps it, driven when `port_ddr` = 1.
- R7: In synchronous mode (`sync_mode` = 1) a frame is the eight data bits LSB first with no start or stop bit. During each bit `sck_out` is 0 for the first OVS/2 cycles and 1 for the rest, so data changes as the clock falls. `sck_out` rests at 1 outside frames.
- R8: In synchronous mode no frame starts while any of `err_overrun`, `err_parity` or `err_framing` is 1, even with `tdr_empty` = 0. During that time `sck_out` stays 1, and the frame starts once the flags clear.
- R9: In asynchronous mode the receive error flags have no effect on starting a frame.
- R10: `tx_end` is 1 after reset and after any cycle with `tx_en` = 0, and goes to 0 in the cycle after `load_ack`. It rises when a stop bit (or last synchronous bit) ends with no data pending. With data pending, the next frame starts in the next cycle without a gap.
- R11: `load_ack` is 1 for exactly the cycle before a frame's first bit. It is only ever 1 while `tdr_empty` is 0 and `tx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock, OVS cycles per bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable; 0 hands the pin to the port bits |
| sync_mode | input | 1 | 1 selects clocked synchronous framing |
| par_en | input | 1 | Adds a parity bit to asynchronous frames |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_data | input | DW | Byte in the holding register |
| tdr_empty | input | 1 | 1 when the holding register has no new byte |
| err_overrun | input | 1 | Receive overrun flag |
| err_parity | input | 1 | Receive parity error flag |
| err_framing | input | 1 | Receive framing error flag |
| port_dr | input | 1 | Port data bit for the pin |
| port_ddr | input | 1 | Port direction bit, 1 = output |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| sck_out | output | 1 | Serial clock for synchronous mode, idles 1 |
| tx_end | output | 1 | Line idle, no frame in progress |
| load_ack | output | 1 | Byte taken from the holding register this cycle |

## Verification
Two events can coincide: the end of a frame's last bit and the start of the next frame, and this is the case that decides whether `tx_end` rises and whether a gap appears. The bench provokes it by writing a new byte as soon as the previous one is acknowledged, and confirms that the second acknowledge comes exactly one frame length after the first while `tx_end` stays 0. A second collision is the disable landing in the same cycle as a load or a last bit. Random toggling of `tx_en` and the error flags against a per-cycle reference model judges that case: the abort must win, the pin must follow the port bits, and `tx_end` must be 1 in the following cycle.

// File: rtl/sertx_pin.sv
module sertx_pin #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          sync_mode,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [DW-1:0] tx_data,
  input  logic          tdr_empty,
  input  logic          err_overrun,
  input  logic          err_parity,
  input  logic          err_framing,
  input  logic          port_dr,
  input  logic          port_ddr,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          sck_out,
  output logic          tx_end,
  output logic          load_ack
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FW + 1);

  logic          busy, fr_sync;
  logic [CW-1:0] tick;
  logic [IW-1:0] idx, nbits;
  logic [FW-1:0] shreg;
  logic [FW-1:0] nxt_frame;
  logic [IW-1:0] nxt_n;

  wire err_any  = err_overrun | err_parity | err_framing;
  wire start_ok = tx_en && !tdr_empty && !(sync_mode && err_any);
  wire bit_end  = busy && (tick == CW'(OVS - 1));
  wire last     = bit_end && (idx == nbits - IW'(1));
  wire par_bit  = (^tx_data) ^ par_odd;

  assign load_ack = start_ok && (!busy || last);
  assign pin_oe   = tx_en ? 1'b1 : port_ddr;
  assign pin_out  = !tx_en ? port_dr : (busy ? shreg[0] : 1'b1);
  assign sck_out  = !(tx_en && busy && fr_sync && (tick < CW'(OVS / 2)));

  always_comb begin
    if (sync_mode) begin
      nxt_frame = {3'b111, tx_data};
      nxt_n     = IW'(DW);
    end else if (par_en) begin
      nxt_frame = {1'b1, par_bit, tx_data, 1'b0};
      nxt_n     = IW'(DW + 3);
    end else begin
      nxt_frame = {2'b11, tx_data, 1'b0};
      nxt_n     = IW'(DW + 2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      fr_sync <= 1'b0;
      tick    <= '0;
      idx     <= '0;
      nbits   <= '0;
      shreg   <= '1;
      tx_end  <= 1'b1;
    end else if (!tx_en) begin
      busy   <= 1'b0;
      tick   <= '0;
      idx    <= '0;
      shreg  <= '1;
      tx_end <= 1'b1;
    end else if (load_ack) begin
      busy    <= 1'b1;
      fr_sync <= sync_mode;
      tick    <= '0;
      idx     <= '0;
      nbits   <= nxt_n;
      shreg   <= nxt_frame;
      tx_end  <= 1'b0;
    end else if (busy) begin
      if (bit_end) begin
        tick  <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        if (last) begin
          busy   <= 1'b0;
          tx_end <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end else begin
        tick <= tick + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sertx_pin_chk.sv
module sertx_pin_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic sync_mode,
  input logic tdr_empty,
  input logic err_overrun,
  input logic err_parity,
  input logic err_framing,
  input logic port_dr,
  input logic port_ddr,
  input logic pin_out,
  input logic pin_oe,
  input logic sck_out,
  input logic tx_end,
  input logic load_ack
);
  // R1
  dis_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (pin_out == port_dr && pin_oe == port_ddr && sck_out));
  // R2
  en_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> pin_oe);
  // R8
  sync_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && (err_overrun || err_parity || err_framing)) |-> !load_ack);
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> !load_ack);
  // R11
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |-> (!tdr_empty && tx_en));
  // R10
  tend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> !tx_end);
  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_end);
endmodule

bind sertx_pin sertx_pin_chk u_chk (.*);

// File: tb/test_sertx_pin.sv
module test_sertx_pin;
  localparam int CLK_P = 10;
  localparam int OVS   = 16;

  logic clk = 0;
  logic rst_n, tx_en, sync_mode, par_en, par_odd, tdr_empty;
  logic err_overrun, err_parity, err_framing, port_dr, port_ddr;
  logic [7:0] tx_data;
  logic pin_out, pin_oe, sck_out, tx_end, load_ack;

  logic d_rst = 0, d_en = 0, d_sync = 0, d_pe = 0, d_po = 0, d_empty = 1;
  logic d_ov = 0, d_pa = 0, d_fr = 0, d_dr = 1, d_ddr = 1;
  logic [7:0] d_data = 0;

  int n_chk = 0, n_fail = 0;
  logic m_busy = 0, m_sync = 0, m_tend = 1, last_ack = 0;
  int m_tick = 0, m_idx = 0, m_n = 0;
  logic [10:0] m_bits = '1;

  always #(CLK_P/2) clk = ~clk;

  sertx_pin #(.OVS(OVS), .DW(8)) i_sertx_pin (.*);

  function automatic logic [10:0] mk_frame(logic [7:0] d, logic s, logic pe, logic po, output int n);
    if (s) begin n = 8; return {3'b111, d}; end
    if (pe) begin n = 11; return {1'b1, ^d ^ po, d, 1'b0}; end
    n = 10; return {2'b11, d, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic step();
    logic e_ok, e_last, e_load, e_pin, e_oe, e_sck;
    int fn;
    @(negedge clk);
    rst_n = d_rst; tx_en = d_en; sync_mode = d_sync; par_en = d_pe; par_odd = d_po;
    tdr_empty = d_empty; tx_data = d_data; err_overrun = d_ov; err_parity = d_pa;
    err_framing = d_fr; port_dr = d_dr; port_ddr = d_ddr;
    #1;
    e_ok   = tx_en && !tdr_empty && !(sync_mode && (d_ov || d_pa || d_fr));
    e_last = m_busy && m_tick == OVS-1 && m_idx == m_n-1;
    e_load = e_ok && (!m_busy || e_last);
    e_pin  = !tx_en ? port_dr : (m_busy ? m_bits[m_idx] : 1'b1);
    e_oe   = tx_en ? 1'b1 : port_ddr;
    e_sck  = !(tx_en && m_busy && m_sync && m_tick < OVS/2);
    chk(pin_out === e_pin, tx_en ? "R3 pin" : "R1 pin", pin_out, e_pin);
    chk(pin_oe === e_oe, tx_en ? "R2 oe" : "R1 oe", pin_oe, e_oe);
    chk(sck_out === e_sck, "R7 sck", sck_out, e_sck);
    chk(load_ack === e_load, "R11 load_ack", load_ack, e_load);
    chk(tx_end === m_tend, "R10 tx_end", tx_end, m_tend);
    last_ack = load_ack;
    if (!rst_n || !tx_en) begin
      m_busy = 0; m_tick = 0; m_idx = 0; m_tend = 1;
    end else if (e_load) begin
      m_bits = mk_frame(tx_data, sync_mode, par_en, par_odd, fn);
      m_n = fn; m_busy = 1; m_tick = 0; m_idx = 0; m_tend = 0; m_sync = sync_mode;
    end else if (m_busy) begin
      if (m_tick == OVS-1) begin
        m_tick = 0;
        if (m_idx == m_n-1) begin m_busy = 0; m_tend = 1; end
        else m_idx++;
      end else m_tick++;
    end
    if (rst_n && e_load) d_empty = 1;
  endtask

  task automatic wait_load(input int lim, output int waited);
    waited = 0;
    do begin step(); waited++; end while (!last_ack && waited < lim);
  endtask

  task automatic capture(input int n, output logic [10:0] got);
    got = '1;
    for (int i = 0; i < n*OVS; i++) begin
      step();
      if (i % OVS == OVS/2) got[i/OVS] = pin_out;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [10:0] got, exp;
    int w, fn, gap;
    bit sck_seen_low, ack_seen;
    void'($urandom(32'h5eed));
    repeat (3) step();
    chk(tx_end === 1'b1, "R10 reset tx_end", tx_end, 1);
    d_rst = 1;
    repeat (2) step();
    chk(pin_out === 1'b1 && pin_oe === 1'b1, "R1 mark before enable", pin_out, 1);

    // R3 plain async frame
    d_en = 1; d_data = 8'hA5; d_empty = 0;
    wait_load(5, w);
    capture(10, got);
    exp = mk_frame(8'hA5, 0, 0, 0, fn);
    chk(got[9:0] === exp[9:0], "R3 frame", got[9:0], exp[9:0]);
    step();
    chk(tx_end === 1'b1 && pin_out === 1'b1, "R10 end idle", tx_end, 1);

    // R4 even then odd parity
    for (int p = 0; p < 2; p++) begin
      d_pe = 1; d_po = p[0]; d_data = 8'h07; d_empty = 0;
      wait_load(5, w);
      capture(11, got);
      exp = mk_frame(8'h07, 0, 1, p[0], fn);
      chk(got[9] === exp[9], "R4 parity bit", got[9], exp[9]);
      chk(got === exp, "R4 frame", got, exp);
    end
    d_pe = 0;

    // R6 break mid-frame
    d_data = 8'hFF; d_empty = 0;
    wait_load(5, w);
    repeat (40) step();
    d_dr = 0; step();
    chk(pin_out === 1'b1, "R6 still framing", pin_out, 1);
    d_en = 0; step();
    chk(pin_out === 1'b0 && pin_oe === 1'b1, "R6 break", pin_out, 0);
    repeat (200) step();
    chk(pin_out === 1'b0, "R6 break held", pin_out, 0);

    // R5 re-enable after abort
    d_dr = 1; d_en = 1; step(); step();
    chk(pin_out === 1'b1 && tx_end === 1'b1, "R5 idle after abort", pin_out, 1);

    // R8 sync blocked by error, then R7 frame
    d_sync = 1; d_pa = 1; d_data = 8'h3C; d_empty = 0;
    ack_seen = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (last_ack) ack_seen = 1;
      if (sck_out !== 1'b1) sck_seen_low = 1;
    end
    chk(!ack_seen, "R8 no start on error", ack_seen, 0);
    chk(tdr_empty === 1'b0 && sck_out === 1'b1, "R8 data held sck idle", tdr_empty, 0);
    d_pa = 0;
    wait_load(3, w);
    chk(w == 1, "R8 start after clear", w, 1);
    step();
    chk(sck_out === 1'b0, "R7 sck falls with first bit", sck_out, 0);
    capture(8, got);
    chk(got[7:0] === 8'h3C, "R7 sync data", got[7:0], 8'h3C);
    d_sync = 0;

    // R9 async ignores errors
    d_fr = 1; d_ov = 1; d_data = 8'h81; d_empty = 0;
    wait_load(3, w);
    chk(w == 1, "R9 start despite errors", w, 1);
    capture(10, got);
    d_fr = 0; d_ov = 0;

    // R10 back-to-back
    repeat (3) step();
    d_data = 8'h55; d_empty = 0;
    wait_load(5, w);
    d_data = 8'hAA; d_empty = 0;
    gap = 0;
    do begin
      step(); gap++;
      if (tx_end !== 1'b0) chk(0, "R10 tx_end during chain", tx_end, 0);
    end while (!last_ack && gap < 400);
    chk(gap == 10*OVS, "R10 no gap", gap, 10*OVS);

    // random phase
    for (int c = 0; c < 20000; c++) begin
      if ($urandom % 900 == 0) d_en = ~d_en;
      if (!d_en && $urandom % 40 == 0) begin
        d_sync = $urandom; d_pe = $urandom; d_po = $urandom;
        d_dr = $urandom; d_ddr = $urandom;
      end
      if (d_empty && $urandom % 50 == 0) begin d_data = $urandom; d_empty = 0; end
      if ($urandom % 300 == 0) begin d_ov = $urandom; d_pa = $urandom; d_fr = $urandom; end
      if ($urandom % 150 == 0) begin d_ov = 0; d_pa = 0; d_fr = 0; end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule